// File: doc/BRIEF.md
# Operand Specifier Effective-Address Unit

This unit resolves one operand specifier of a 16-bit, byte-addressed machine with eight general registers, where register 6 serves as the stack pointer and register 7 as the program counter. A specifier is a 3-bit mode and a 3-bit register number. On a start strobe the unit reads the chosen register from an external register file. It applies any post-increment or pre-decrement to that register and writes the new value back. When the mode calls for it, the unit fetches an index word or an indirect pointer over a simple memory read port with a ready handshake.

When it finishes, the unit pulses done. At the same time it reports one of three results: the operand is the register itself, the operand lives at a final effective address, or the specifier was illegal. Used with register 7, the same eight modes give immediate, absolute, relative and relative-indirect forms without any extra encoding. Fetching and storing the operand data itself is left to the surrounding datapath.

Top module: `opspec_ea_unit`

## Requirements
- R1: Mode 0 raises no memory read and no register write. It reports is_reg=1 when need_addr=0. When need_addr=1 it reports illegal=1 with is_reg=0 instead, and ea is 0.
- R2: Mode 1 reports ea equal to the register contents and leaves the register unchanged.
- R3: Mode 2 reports ea equal to the old register value and writes back the old value plus the step. With register 7 this addresses the immediate word that follows.
- R4: Mode 3 reads the word at the old register value and reports it as ea. The register is written back as old value plus 2. With register 7 this gives an absolute address.
- R5: Mode 4 writes back the register minus the step and reports that new value as ea.
- R6: Mode 5 writes back the register minus 2 and reports as ea the word read at that new value.
- R7: Modes 6 and 7 first read an index word at the address in register 7 and write register 7 back plus 2. They then add the index to the selected register, read after that update, so register 7 gives a relative address based on the advanced program counter. Mode 6 reports this sum as ea.
- R8: Mode 7 reports as ea the word read at the mode-6 sum.
- R9: The step is 1 for a byte operation (byte_op=1) on registers 0 to 5 in modes 2 and 4. In every other case it is 2, including register 6, register 7, and modes 3 and 5.
- R10: Each specifier produces exactly one register write in modes 2 to 7 and none in modes 0 and 1. Done is a single-cycle pulse.
- R11: A memory read is issued only for an index word or an indirect pointer: one in modes 3, 5 and 6, two in mode 7. Each read holds mem_req and mem_addr steady until mem_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a specifier; sampled while the unit is idle |
| mode | input | 3 | Addressing mode 0 to 7 |
| rnum | input | 3 | Register number 0 to 7 |
| byte_op | input | 1 | Operand is a byte (affects step size) |
| need_addr | input | 1 | The instruction requires a memory operand |
| rf_rd_sel | output | 3 | Register file read select |
| rf_rd_data | input | 16 | Register file read data (combinational) |
| rf_wr_en | output | 1 | Register write enable |
| rf_wr_sel | output | 3 | Register write select |
| rf_wr_data | output | 16 | Register write data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Memory read completes this cycle |
| done | output | 1 | One-cycle completion pulse |
| is_reg | output | 1 | Operand is the register itself (valid with done) |
| illegal | output | 1 | Illegal addressing mode (valid with done) |
| ea | output | 16 | Final effective address (valid with done) |

## Verification
Any corruption of the latched mode, register number or step shows up at the register write port in the very next cycle as a wrong select, or as a write value that is off by 1 or 2. A stale pointer or index register instead appears on mem_addr during the next read, or in ea at the done pulse, within a few cycles of the memory latency. The bench keeps its own register file and memory. After every specifier it compares the full register file, the count of writes and reads, and the reported result, so a miss in any register surfaces by the end of the specifier that caused it.

// File: rtl/opspec_ea_unit.sv
module opspec_ea_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   mode,
  input  logic [2:0]   rnum,
  input  logic         byte_op,
  input  logic         need_addr,
  output logic [2:0]   rf_rd_sel,
  input  logic [W-1:0] rf_rd_data,
  output logic         rf_wr_en,
  output logic [2:0]   rf_wr_sel,
  output logic [W-1:0] rf_wr_data,
  output logic         mem_req,
  output logic [W-1:0] mem_addr,
  input  logic [W-1:0] mem_rdata,
  input  logic         mem_ready,
  output logic         done,
  output logic         is_reg,
  output logic         illegal,
  output logic [W-1:0] ea
);
  localparam logic [2:0] PC_REG = 3'd7;

  typedef enum logic [2:0] {S_IDLE, S_BASE, S_IDX, S_ADD, S_DEFR} st_t;
  st_t st;

  logic [2:0]   m_q, r_q;
  logic         b_q, n_q;
  logic [W-1:0] ptr_q, idx_q;
  logic [W-1:0] step, inc_v, dec_v, sum_v;

  assign step  = (b_q && r_q < 3'd6 && (m_q == 3'd2 || m_q == 3'd4)) ? W'(1) : W'(2);
  assign inc_v = rf_rd_data + step;
  assign dec_v = rf_rd_data - step;
  assign sum_v = rf_rd_data + idx_q;

  assign rf_rd_sel  = (st == S_IDX) ? PC_REG : r_q;
  assign rf_wr_en   = (st == S_BASE && m_q >= 3'd2 && m_q <= 3'd5) || (st == S_IDX && mem_ready);
  assign rf_wr_sel  = (st == S_IDX) ? PC_REG : r_q;
  assign rf_wr_data = (st == S_IDX) ? rf_rd_data + W'(2) : (m_q[2] ? dec_v : inc_v);
  assign mem_req    = (st == S_IDX) || (st == S_DEFR);
  assign mem_addr   = (st == S_IDX) ? rf_rd_data : ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; m_q <= '0; r_q <= '0; b_q <= 1'b0; n_q <= 1'b0;
      ptr_q <= '0; idx_q <= '0; done <= 1'b0; is_reg <= 1'b0;
      illegal <= 1'b0; ea <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          m_q <= mode; r_q <= rnum; b_q <= byte_op; n_q <= need_addr;
          is_reg <= 1'b0; illegal <= 1'b0;
          st <= S_BASE;
        end
        S_BASE: begin
          case (m_q)
            3'd0: begin
              is_reg <= !n_q; illegal <= n_q; ea <= '0;
              done <= 1'b1; st <= S_IDLE;
            end
            3'd1, 3'd2: begin ea <= rf_rd_data; done <= 1'b1; st <= S_IDLE; end
            3'd3: begin ptr_q <= rf_rd_data; st <= S_DEFR; end
            3'd4: begin ea <= dec_v; done <= 1'b1; st <= S_IDLE; end
            3'd5: begin ptr_q <= dec_v; st <= S_DEFR; end
            default: st <= S_IDX;
          endcase
        end
        S_IDX: if (mem_ready) begin idx_q <= mem_rdata; st <= S_ADD; end
        S_ADD: begin
          if (m_q[0]) begin ptr_q <= sum_v; st <= S_DEFR; end
          else begin ea <= sum_v; done <= 1'b1; st <= S_IDLE; end
        end
        S_DEFR: if (mem_ready) begin ea <= mem_rdata; done <= 1'b1; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |=> !rf_wr_en);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  // R1
  illegal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && illegal) |-> (!is_reg && ea == '0));

  // R9
  wide_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr_en && rf_wr_sel[2:1] == 2'b11) |->
      (rf_wr_data - rf_rd_data == W'(2) || rf_rd_data - rf_wr_data == W'(2)));
endmodule

// File: tb/opspec_ea_unit_test.sv
module opspec_ea_unit_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, byte_op = 1'b0, need_addr = 1'b0;
  logic [2:0] mode = '0, rnum = '0;
  logic [2:0] rf_rd_sel, rf_wr_sel;
  logic [15:0] rf_rd_data, rf_wr_data, mem_addr, ea;
  logic [15:0] mem_rdata = '0;
  logic rf_wr_en, mem_req, done, is_reg, illegal;
  logic mem_ready = 1'b0;

  logic [15:0] regs [8];
  int checks = 0, errors = 0, wcount = 0, mcount = 0, lat = 0, wcnt = 0;

  always #10 clk = ~clk;

  opspec_ea_unit uut (.clk, .rst_n, .start, .mode, .rnum, .byte_op, .need_addr,
    .rf_rd_sel, .rf_rd_data, .rf_wr_en, .rf_wr_sel, .rf_wr_data,
    .mem_req, .mem_addr, .mem_rdata, .mem_ready, .done, .is_reg, .illegal, .ea);

  assign rf_rd_data = regs[rf_rd_sel];

  function automatic logic [15:0] memf(input logic [15:0] a);
    return {a[7:0] ^ 8'hA5, a[15:8] + 8'h13};
  endfunction

  always @(posedge clk) begin
    if (rf_wr_en) begin regs[rf_wr_sel] <= rf_wr_data; wcount++; end
    if (mem_req && mem_ready) mcount++;
  end

  initial forever begin
    @(negedge clk);
    if (mem_ready) begin mem_ready = 1'b0; wcnt = 0; end
    if (mem_req) begin
      mem_rdata = memf(mem_addr);
      if (wcnt >= lat) mem_ready = 1'b1; else wcnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input int m, input int r, input bit b, input bit n, input int l);
    logic [15:0] er [8];
    logic [15:0] eea, p, x, stp;
    bit eisreg, eill;
    int ew, em, t;
    string tag;
    for (int i = 0; i < 8; i++) er[i] = regs[i];
    stp = (b && r < 6 && (m == 2 || m == 4)) ? 16'd1 : 16'd2;
    eea = '0; eisreg = 0; eill = 0; ew = 0; em = 0;
    case (m)
      0: begin eisreg = !n; eill = n; tag = "R1"; end
      1: begin eea = er[r]; tag = "R2"; end
      2: begin eea = er[r]; er[r] = er[r] + stp; ew = 1; tag = "R3"; end
      3: begin p = er[r]; er[r] = er[r] + 16'd2; eea = memf(p); ew = 1; em = 1; tag = "R4"; end
      4: begin er[r] = er[r] - stp; eea = er[r]; ew = 1; tag = "R5"; end
      5: begin er[r] = er[r] - 16'd2; eea = memf(er[r]); ew = 1; em = 1; tag = "R6"; end
      6: begin x = memf(er[7]); er[7] = er[7] + 16'd2; eea = er[r] + x; ew = 1; em = 1; tag = "R7"; end
      default: begin x = memf(er[7]); er[7] = er[7] + 16'd2; eea = memf(er[r] + x); ew = 1; em = 2; tag = "R8"; end
    endcase
    @(negedge clk);
    lat = l; wcount = 0; mcount = 0;
    mode = 3'(m); rnum = 3'(r); byte_op = b; need_addr = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 100) begin @(negedge clk); t++; end
    chk(done, {tag, " done timeout"}, 16'(done), 16'd1);
    chk(ea == eea && is_reg == eisreg && illegal == eill, {tag, " ea/is_reg/illegal"},
        ea, eea);
    for (int i = 0; i < 8; i++)
      chk(regs[i] == er[i], {tag, " R9 register file"}, regs[i], er[i]);
    chk(wcount == ew, "R10 write count", 16'(wcount), 16'(ew));
    chk(mcount == em, "R11 read count", 16'(mcount), 16'(em));
    @(negedge clk);
    chk(!done, "R10 done pulse", 16'(done), 16'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) regs[i] = 16'h1000 + 16'(i) * 16'h0123;
    regs[7] = 16'h2000;
    repeat (3) @(negedge clk);
    chk(!done && !mem_req && !rf_wr_en, "reset outputs idle", {13'd0, done, mem_req, rf_wr_en}, 16'd0);
    rst_n = 1'b1;
    // R1 both need_addr settings
    run(0, 2, 0, 0, 0);
    run(0, 5, 1, 1, 0);
    // R2..R8 across registers, byte/word, latencies; R9 steps
    for (int m = 1; m < 8; m++)
      for (int k = 0; k < 4; k++)
        for (int b = 0; b < 2; b++)
          run(m, (k == 0) ? 0 : (k == 1) ? 3 : (k == 2) ? 6 : 7, b[0], 1'b1, (m + k + b) % 3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule